// File: doc/BRIEF.md
# Planemasked Raster-Op Vector Unit

This execution unit sits inside a graphics microcode engine and merges wide pixel vectors under a stored raster operation and plane mask. It keeps two pieces of state: a 32-bit plane mask and a 4-bit raster-op code. A state-load instruction copies both from the low bits of operand A. A combine instruction then treats operand A as the destination pixels and operand B as the source pixels. It processes the 256-bit vector as eight independent 32-bit lanes.

In every lane, bit positions where the plane mask is one receive the raster-op result of source and destination. Bit positions where the mask is zero pass the destination bits through unchanged. The same 32-bit mask applies to all lanes. The state-load instruction answers at once with a zero result. The combine result is registered and appears one cycle after its start strobe. The register file, the sequencer and the memory path sit outside this block.

Top module: `pmrop_unit`

## Requirements
- R1: On reset the plane mask becomes all ones and the raster-op code becomes 3 (copy source). `valid` is low while no operation is in progress.
- R2: The 5-bit opcode 12 is the state load and opcode 2 is the combine. When `start` is high with any other opcode, `valid` stays low in that cycle and in the next, and the stored state does not change.
- R3: A state load takes the plane mask from operand A bits 31:0 and the code from operand A bits 35:32, and ignores all higher bits. The new state governs every combine that starts in a later cycle.
- R4: In the same cycle as a state-load `start`, `valid` is high and `result` is zero.
- R5: `valid` goes high exactly one cycle after a combine `start`, and `result` then carries the combined vector. Without `start`, `valid` stays low.
- R6: In each lane i (bits 32i+31:32i), result = (rop(B_i, A_i) AND mask) OR (A_i AND NOT mask), with one 32-bit mask shared by all eight lanes.
- R7: Each output bit of rop for source bit s and destination bit d is a code bit. Code bit 0 applies when s=1 and d=1, bit 1 when s=1 and d=0, bit 2 when s=0 and d=1, and bit 3 when s=0 and d=0. So code 0 clears, 3 copies the source, 5 keeps the destination, 6 is XOR and 15 sets.
- R8: Where the plane mask bit is zero, the combine result bit equals the operand A bit, whatever the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe for the current opcode |
| opcode | input | 5 | Operation select (2 combine, 12 state load) |
| opnd_a | input | 256 | Destination data, or the state word for a load |
| opnd_b | input | 256 | Source data |
| result | output | 256 | Combined vector, or zero for a state load |
| valid | output | 1 | Result is valid this cycle |

## Verification
If the stored mask or code is wrong, nothing shows until a later combine. That combine's result then differs one cycle after its start, either in masked bits (a wrong code) or in bits that should pass A through (a wrong mask). Each state load is therefore followed directly by a combine whose lanes hold different data. This catches a stale, swapped or partly replicated state on the very next result. A wrong decode shows in the same cycle as a missing or spurious `valid`. It also shows one operation later, as state that changed when it should not have.

// File: rtl/pmrop_pkg.sv
package pmrop_pkg;

    localparam int LANE_W   = 32;
    localparam int CODE_W   = 4;
    localparam int OPC_W    = 5;
    localparam int STATE_W  = LANE_W + CODE_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_COMBINE  = 5'd2,
        OPC_SETSTATE = 5'd12
    } opc_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LANE_W-1:0] mask;
    } rop_state_t;

    localparam rop_state_t STATE_RESET = '{code: 4'd3, mask: '1};

    // Output bit chosen by code bit index {~src, ~dst}
    function automatic logic [LANE_W-1:0] rop_eval(
        input logic [CODE_W-1:0] c,
        input logic [LANE_W-1:0] s,
        input logic [LANE_W-1:0] d
    );
        return ({LANE_W{c[0]}} &  s &  d) |
               ({LANE_W{c[1]}} &  s & ~d) |
               ({LANE_W{c[2]}} & ~s &  d) |
               ({LANE_W{c[3]}} & ~s & ~d);
    endfunction

endpackage

// File: rtl/pmrop_decode.sv
module pmrop_decode
    import pmrop_pkg::*;
(
    input  logic             start,
    input  logic [OPC_W-1:0] opcode,
    output logic             fire_set,
    output logic             fire_comb
);
    always_comb begin
        fire_set  = start && (opcode == OPC_SETSTATE);
        fire_comb = start && (opcode == OPC_COMBINE);
    end
endmodule

// File: rtl/pmrop_state.sv
module pmrop_state
    import pmrop_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [STATE_W-1:0] load_word,
    output rop_state_t         state_q
);
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= STATE_RESET;
        else if (load)
            state_q <= rop_state_t'(load_word);
    end

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(state_q));  // R2

    AST_STATE_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (state_q == $past(load_word)));  // R3
endmodule

// File: rtl/pmrop_lane.sv
module pmrop_lane
    import pmrop_pkg::*;
(
    input  rop_state_t        st,
    input  logic [LANE_W-1:0] dst,
    input  logic [LANE_W-1:0] src,
    output logic [LANE_W-1:0] q
);
    logic [LANE_W-1:0] raw;

    always_comb begin
        raw = rop_eval(st.code, src, dst);
        q   = (raw & st.mask) | (dst & ~st.mask);
    end
endmodule

// File: rtl/pmrop_unit.sv
module pmrop_unit
    import pmrop_pkg::*;
#(
    parameter int NUM_LANES = 8,
    localparam int VEC_W    = NUM_LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [4:0]       opcode,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic [VEC_W-1:0] result,
    output logic             valid
);
    logic             fire_set;
    logic             fire_comb;
    rop_state_t       st_q;
    logic [VEC_W-1:0] comb_d;
    logic [VEC_W-1:0] comb_q;
    logic             comb_vld_q;

    pmrop_decode u_dec (
        .start     (start),
        .opcode    (opcode),
        .fire_set  (fire_set),
        .fire_comb (fire_comb)
    );

    pmrop_state u_state (
        .clk       (clk),
        .rst       (rst),
        .load      (fire_set),
        .load_word (opnd_a[STATE_W-1:0]),
        .state_q   (st_q)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        pmrop_lane u_lane (
            .st  (st_q),
            .dst (opnd_a[i*LANE_W +: LANE_W]),
            .src (opnd_b[i*LANE_W +: LANE_W]),
            .q   (comb_d[i*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_q     <= '0;
            comb_vld_q <= 1'b0;
        end else begin
            comb_vld_q <= fire_comb;
            if (fire_comb)
                comb_q <= comb_d;
        end
    end

    always_comb begin
        valid  = fire_set | comb_vld_q;
        result = fire_set ? '0 : comb_q;
    end

    AST_SET_ACK: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == 5'd12) |-> (valid && result == '0));  // R4

    AST_COMB_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == 5'd2) |=> valid);  // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (valid && !(start && opcode == 5'd12)) |-> $past(start && opcode == 5'd2));  // R2

    AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
        comb_vld_q |-> (((comb_q ^ $past(opnd_a)) & ~{NUM_LANES{$past(st_q.mask)}}) == '0));  // R8
endmodule

// File: tb/sim_pmrop_unit.sv
module sim_pmrop_unit;
    localparam int NL = 8;
    localparam int W  = NL * 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [4:0]   opcode = '0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    pmrop_unit u0 (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .valid(valid)
    );

    always #5 clk = ~clk;

    // mask[99:68] code[67:64] a_word[63:32] b_word[31:0]
    localparam logic [99:0] VEC [8] = '{
        {32'hFFFFFFFF, 4'd3,  32'h12345678, 32'hCAFEF00D},
        {32'hFFFFFFFF, 4'd0,  32'hA5A5A5A5, 32'h0F0F0F0F},
        {32'hFFFFFFFF, 4'd15, 32'h00000000, 32'h13579BDF},
        {32'h0000FFFF, 4'd6,  32'hDEADBEEF, 32'h0BADF00D},
        {32'hF0F0F0F0, 4'd1,  32'h3C3C3C3C, 32'hFF00FF00},
        {32'h00000000, 4'd12, 32'h89ABCDEF, 32'h76543210},
        {32'h80000001, 4'd5,  32'h11112222, 32'hEEEEDDDD},
        {32'h5A5AA5A5, 4'd14, 32'hC0FFEE00, 32'h00FACADE}
    };

    function automatic logic [W-1:0] spread(input logic [31:0] w, input logic [31:0] step);
        logic [W-1:0] v;
        for (int i = 0; i < NL; i++) v[i*32 +: 32] = w ^ (step * i);
        return v;
    endfunction

    // Reference from the requirement table: code bit 0 for s=1,d=1 ... bit 3 for s=0,d=0
    function automatic logic [W-1:0] model(input logic [31:0] m, input logic [3:0] c,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) begin
            logic bitv;
            case ({b[k], a[k]})
                2'b11: bitv = c[0];
                2'b10: bitv = c[1];
                2'b01: bitv = c[2];
                default: bitv = c[3];
            endcase
            r[k] = m[k % 32] ? bitv : a[k];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_set(input logic [31:0] m, input logic [3:0] c, input string tag);
        @(negedge clk);
        start = 1'b1; opcode = 5'd12;
        opnd_a = {{(W-36){1'b1}}, c, m};
        opnd_b = {W{1'b1}};
        #1;
        check({tag, " R4 set valid"}, W'(valid), W'(1'b1));
        check({tag, " R4 set zero"}, result, '0);
    endtask

    task automatic do_comb(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        start = 1'b1; opcode = 5'd2; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 1'b0; opnd_a = ~a; opnd_b = ~b;
        #1;
        check({tag, " R5 valid"}, W'(valid), W'(1'b1));
        check({tag, " R6 result"}, result, exp);
    endtask

    initial begin
        logic [W-1:0] a, b, a2, b2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 valid low after reset", W'(valid), '0);

        // R1: default state copies source under a full mask
        a = spread(32'h01234567, 32'h11111111);
        b = spread(32'h89ABCDEF, 32'h01010101);
        do_comb(a, b, b, "R1 default copy");

        // Table walk: R3 R6 R7 R8
        for (int t = 0; t < 8; t++) begin
            logic [31:0] m;
            logic [3:0]  c;
            m = VEC[t][99:68];
            c = VEC[t][67:64];
            a = spread(VEC[t][63:32], 32'h01010101);
            b = spread(VEC[t][31:0],  32'h10203040);
            do_set(m, c, $sformatf("R3 vec%0d", t));
            do_comb(a, b, model(m, c, a, b), $sformatf("R7 R8 vec%0d", t));
        end

        // R2: foreign opcode changes nothing and gives no valid
        do_set(32'hFFFFFFFF, 4'd0, "R2 prep");
        @(negedge clk);
        start = 1'b1; opcode = 5'd7; opnd_a = {W{1'b1}};
        #1;
        check("R2 no valid same cycle", W'(valid), '0);
        @(negedge clk);
        start = 1'b0;
        #1;
        check("R2 no valid next cycle", W'(valid), '0);
        a = spread(32'h55AA55AA, 32'h0F0F0F0F);
        b = spread(32'hFFFFFFFF, 32'h0);
        do_comb(a, b, '0, "R2 state kept");

        // R5: opcode present without start
        @(negedge clk);
        start = 1'b0; opcode = 5'd2;
        @(negedge clk);
        #1;
        check("R5 no valid without start", W'(valid), '0);

        // R5: back-to-back combines
        do_set(32'hFFFFFFFF, 4'd6, "R5 prep");
        a  = spread(32'h0000FFFF, 32'h00010001);
        b  = spread(32'hFFFF0000, 32'h02000200);
        a2 = spread(32'h12121212, 32'h03030303);
        b2 = spread(32'h34343434, 32'h00700070);
        @(negedge clk);
        start = 1'b1; opcode = 5'd2; opnd_a = a; opnd_b = b;
        @(negedge clk);
        opnd_a = a2; opnd_b = b2;
        #1;
        check("R5 first of pair", result, a ^ b);
        @(negedge clk);
        start = 1'b0;
        #1;
        check("R5 second of pair", result, a2 ^ b2);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule